// File: doc/BRIEF.md
# Microcoded 16-bit Register Processor

This block is a small word-addressed processor core. A microsequencer walks through control words held in a constant microcode store. Each control word is looked up from the current opcode together with a short step count. The core owns eight general-purpose 16-bit registers, a sixteen-function ALU, an instruction register, an immediate register and a zero/negative flag pair. It reaches one unified memory through a single synchronous port with 16-bit addresses and 16-bit words.

The memory presents read data in the cycle after a read request. A write is taken at the clock edge that ends the cycle in which it is requested. Every instruction begins with a two-cycle fetch. The opcode then picks a short microcode routine of one to three steps, after which control returns to the fetch. Instructions that carry a literal occupy two consecutive words. The core runs from address 0 after reset and stops for good when it executes the halt opcode.

Top module: `ucpu_core`

## Requirements
- R1: While reset is applied and right after it, PC is 0, the core requests a read of address 0, it does not write, `halted` is low, and all eight registers hold 0.
- R2: An instruction word is split as op = bits [15:9], t = [8:6], s = [5:3], d = [2:0]. Each instruction is fetched by one read at PC in its first cycle, followed by one idle cycle. PC then advances by exactly 1 per word consumed.
- R3: Opcodes 0x00 to 0x0F write d = f(s, t) with f = op[3:0]. The functions are 0 add, 1 s-t, 2 and, 3 or, 4 xor, 5 not s, 6 s<<1, 7 logical s>>1, 8 arithmetic s>>1, 9 s, 10 t, 11 s+1, 12 s-1, 13 -s, 14 nand, 15 nor. These take 3 cycles and make no memory access after the fetch.
- R4: Opcode 0x10 loads d with the word that follows the instruction. The following word is read in cycle 3, and the instruction takes 5 cycles.
- R5: Opcode 0x11 reads memory at address reg[s] in cycle 3 and loads the returned word into d. The instruction takes 4 cycles.
- R6: Opcode 0x12 writes reg[t] to address reg[s] in cycle 3, in a single write cycle that carries no read. The instruction takes 3 cycles.
- R7: Opcode 0x13 sets PC to the literal word that follows it. The instruction takes 5 cycles.
- R8: Opcode 0x14 jumps to its literal when reg[s] is zero, and opcode 0x15 jumps when reg[s] bit 15 is set. Otherwise execution continues at the word after the literal. Both take 5 cycles.
- R9: Any opcode not named in R3 to R8 or R10 does nothing for 3 cycles.
- R10: Opcode 0x7F raises `halted` from the cycle after its third cycle. From then on, `halted` stays high and the core makes no read or write until reset.
- R11: A store followed by a load of the same address returns the stored value, and a register written by one instruction is seen by the next.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| mem_addr | output | 16 | Word address of the current access |
| mem_re | output | 1 | Read request; data returns on `mem_rdata` the next cycle |
| mem_we | output | 1 | Write request, taken at the next clock edge |
| mem_wdata | output | 16 | Write data |
| mem_rdata | input | 16 | Read data, one cycle after `mem_re` |
| halted | output | 1 | High once the halt opcode has executed |

## Verification
The in-line assertions watch several properties on every cycle. Reads and writes never share a cycle, and a write is always followed by a non-write cycle. A fetch request always leads to the instruction-register load and then to dispatch. PC steps by one whenever the control word asks for an increment, and a raised `halted` never falls. The correctness of ALU results, literal capture, load data, branch direction and per-instruction cycle counts is shown only by the bench. Its behavioural instruction model rebuilds the expected bus trace cycle by cycle and compares it with every cycle of a program that exercises all sixteen functions, taken and untaken branches, store-then-load, an unassigned opcode and halt.

// File: rtl/ucpu_pkg.sv
package ucpu_pkg;
  localparam int DW   = 16;
  localparam int OPW  = 7;
  localparam int NREG = 8;
  localparam int STW  = 2;

  localparam logic [OPW-1:0] OP_LDI  = 7'h10;
  localparam logic [OPW-1:0] OP_LD   = 7'h11;
  localparam logic [OPW-1:0] OP_ST   = 7'h12;
  localparam logic [OPW-1:0] OP_JMP  = 7'h13;
  localparam logic [OPW-1:0] OP_BZ   = 7'h14;
  localparam logic [OPW-1:0] OP_BN   = 7'h15;
  localparam logic [OPW-1:0] OP_HALT = 7'h7F;

  typedef enum logic [3:0] {
    FN_ADD, FN_SUB, FN_AND, FN_OR, FN_XOR, FN_NOTA, FN_SHL, FN_SHR,
    FN_SRA, FN_PASSA, FN_PASSB, FN_INC, FN_DEC, FN_NEG, FN_NAND, FN_NOR
  } alu_fn_e;

  typedef enum logic       {AS_PC, AS_SREG} asel_e;
  typedef enum logic [1:0] {WS_ALU, WS_MEM, WS_IMM} wsel_e;
  typedef enum logic [1:0] {PJ_NONE, PJ_ALWAYS, PJ_ZERO, PJ_NEG} pcj_e;
  typedef enum logic [1:0] {NX_FETCH, NX_STEP, NX_DISPATCH, NX_HALT} nxt_e;

  typedef struct packed {
    asel_e   asel;
    logic    rd;
    logic    wr;
    logic    pc_inc;
    logic    ir_ld;
    logic    imm_ld;
    alu_fn_e fn;
    logic    rf_we;
    wsel_e   wsel;
    logic    flg_ld;
    pcj_e    pcj;
    nxt_e    nxt;
  } uop_t;
endpackage

// File: rtl/ucpu_alu.sv
module ucpu_alu
  import ucpu_pkg::*;
#(
  parameter int W = DW
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  alu_fn_e      fn,
  output logic [W-1:0] y,
  output logic         zero,
  output logic         neg
);
  always_comb begin
    unique case (fn)
      FN_ADD:   y = a + b;
      FN_SUB:   y = a - b;
      FN_AND:   y = a & b;
      FN_OR:    y = a | b;
      FN_XOR:   y = a ^ b;
      FN_NOTA:  y = ~a;
      FN_SHL:   y = {a[W-2:0], 1'b0};
      FN_SHR:   y = {1'b0, a[W-1:1]};
      FN_SRA:   y = {a[W-1], a[W-1:1]};
      FN_PASSA: y = a;
      FN_PASSB: y = b;
      FN_INC:   y = a + 1'b1;
      FN_DEC:   y = a - 1'b1;
      FN_NEG:   y = ~a + 1'b1;
      FN_NAND:  y = ~(a & b);
      FN_NOR:   y = ~(a | b);
      default:  y = '0;
    endcase
  end

  assign zero = (y == '0);
  assign neg  = y[W-1];
endmodule

// File: rtl/ucpu_regfile.sv
module ucpu_regfile
  import ucpu_pkg::*;
#(
  parameter int W  = DW,
  parameter int NR = NREG,
  localparam int IW = $clog2(NR)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [IW-1:0] widx,
  input  logic [W-1:0]  wdata,
  input  logic [IW-1:0] ra_idx,
  output logic [W-1:0]  ra_data,
  input  logic [IW-1:0] rb_idx,
  output logic [W-1:0]  rb_data
);
  logic [NR-1:0][W-1:0] bank;

  for (genvar g = 0; g < NR; g++) begin : g_reg
    logic         en;
    logic [W-1:0] q;
    assign en = we && (widx == IW'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  q <= '0;
      else if (en) q <= wdata;
    end
    assign bank[g] = q;
  end

  assign ra_data = bank[ra_idx];
  assign rb_data = bank[rb_idx];
endmodule

// File: rtl/ucpu_useq.sv
module ucpu_useq
  import ucpu_pkg::*;
#(
  parameter int OW = OPW,
  parameter int SW = STW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [OW-1:0] op,
  output uop_t          uop,
  output logic          halted
);
  logic          fetch_q, fetch_d;
  logic [SW-1:0] step_q, step_d;
  logic          halt_q, halt_d;

  function automatic uop_t rom_word(input logic f, input logic [OW-1:0] o,
                                    input logic [SW-1:0] s);
    uop_t u;
    u = '0;
    if (f) begin
      if (s == '0) begin
        u.asel = AS_PC; u.rd = 1'b1; u.pc_inc = 1'b1; u.nxt = NX_STEP;
      end else begin
        u.ir_ld = 1'b1; u.nxt = NX_DISPATCH;
      end
    end else if (o < OW'(16)) begin
      if (s == '0) begin
        u.fn = alu_fn_e'(o[3:0]); u.rf_we = 1'b1; u.wsel = WS_ALU;
        u.flg_ld = 1'b1; u.nxt = NX_FETCH;
      end
    end else begin
      unique case (o)
        OP_LDI: begin
          if (s == SW'(0)) begin
            u.rd = 1'b1; u.pc_inc = 1'b1; u.nxt = NX_STEP;
          end else if (s == SW'(1)) begin
            u.imm_ld = 1'b1; u.nxt = NX_STEP;
          end else begin
            u.rf_we = 1'b1; u.wsel = WS_IMM; u.nxt = NX_FETCH;
          end
        end
        OP_LD: begin
          if (s == SW'(0)) begin
            u.asel = AS_SREG; u.rd = 1'b1; u.nxt = NX_STEP;
          end else begin
            u.rf_we = 1'b1; u.wsel = WS_MEM; u.nxt = NX_FETCH;
          end
        end
        OP_ST: begin
          u.asel = AS_SREG; u.wr = 1'b1; u.nxt = NX_FETCH;
        end
        OP_JMP, OP_BZ, OP_BN: begin
          if (s == SW'(0)) begin
            u.rd = 1'b1; u.pc_inc = 1'b1; u.nxt = NX_STEP;
          end else if (s == SW'(1)) begin
            u.imm_ld = 1'b1; u.fn = FN_PASSA; u.flg_ld = (o != OP_JMP);
            u.nxt = NX_STEP;
          end else begin
            u.pcj = (o == OP_JMP) ? PJ_ALWAYS :
                    (o == OP_BZ)  ? PJ_ZERO   : PJ_NEG;
            u.nxt = NX_FETCH;
          end
        end
        OP_HALT: u.nxt = NX_HALT;
        default: u.nxt = NX_FETCH;
      endcase
    end
    return u;
  endfunction

  assign uop    = halt_q ? uop_t'('0) : rom_word(fetch_q, op, step_q);
  assign halted = halt_q;

  always_comb begin
    fetch_d = fetch_q;
    step_d  = step_q;
    halt_d  = halt_q;
    if (!halt_q) begin
      unique case (uop.nxt)
        NX_STEP:     step_d = step_q + 1'b1;
        NX_DISPATCH: begin fetch_d = 1'b0; step_d = '0; end
        NX_FETCH:    begin fetch_d = 1'b1; step_d = '0; end
        NX_HALT:     halt_d = 1'b1;
        default:     begin fetch_d = 1'b1; step_d = '0; end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fetch_q <= 1'b1;
      step_q  <= '0;
      halt_q  <= 1'b0;
    end else begin
      fetch_q <= fetch_d;
      step_q  <= step_d;
      halt_q  <= halt_d;
    end
  end

  AST_HALT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    halt_q |=> halt_q); // R10
  AST_FETCH_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_q && step_q == '0 && !halt_q) |=> (fetch_q && step_q == SW'(1))); // R2
  AST_DISPATCH: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_q && step_q == SW'(1) && !halt_q) |=> (!fetch_q && step_q == '0)); // R2
endmodule

// File: rtl/ucpu_core.sv
module ucpu_core
  import ucpu_pkg::*;
#(
  parameter int W  = DW,
  parameter int OW = OPW,
  parameter int NR = NREG,
  localparam int IW = $clog2(NR)
) (
  input  logic         clk,
  input  logic         rst_n,
  output logic [W-1:0] mem_addr,
  output logic         mem_re,
  output logic         mem_we,
  output logic [W-1:0] mem_wdata,
  input  logic [W-1:0] mem_rdata,
  output logic         halted
);
  logic rst_meta, rst_core;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_core <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_core <= rst_meta;
    end
  end

  logic [W-1:0] pc_q, pc_d, ir_q, ir_d, imm_q, imm_d;
  logic         z_q, z_d, n_q, n_d;
  uop_t         uop;

  logic [OW-1:0] op;
  logic [IW-1:0] t_idx, s_idx, d_idx;
  assign op    = ir_q[W-1 -: OW];
  assign t_idx = ir_q[3*IW-1 -: IW];
  assign s_idx = ir_q[2*IW-1 -: IW];
  assign d_idx = ir_q[IW-1:0];

  ucpu_useq #(.OW(OW), .SW(STW)) u_seq (
    .clk(clk), .rst_n(rst_core), .op(op), .uop(uop), .halted(halted)
  );

  logic [W-1:0] rs_data, rt_data, alu_y, wb_data;
  logic         alu_z, alu_n;

  ucpu_alu #(.W(W)) u_alu (
    .a(rs_data), .b(rt_data), .fn(uop.fn), .y(alu_y), .zero(alu_z), .neg(alu_n)
  );

  always_comb begin
    unique case (uop.wsel)
      WS_MEM:  wb_data = mem_rdata;
      WS_IMM:  wb_data = imm_q;
      default: wb_data = alu_y;
    endcase
  end

  ucpu_regfile #(.W(W), .NR(NR)) u_rf (
    .clk(clk), .rst_n(rst_core), .we(uop.rf_we), .widx(d_idx), .wdata(wb_data),
    .ra_idx(s_idx), .ra_data(rs_data), .rb_idx(t_idx), .rb_data(rt_data)
  );

  logic take;
  always_comb begin
    unique case (uop.pcj)
      PJ_ALWAYS: take = 1'b1;
      PJ_ZERO:   take = z_q;
      PJ_NEG:    take = n_q;
      default:   take = 1'b0;
    endcase
  end

  always_comb begin
    pc_d  = pc_q;
    ir_d  = ir_q;
    imm_d = imm_q;
    z_d   = z_q;
    n_d   = n_q;
    if (take)             pc_d  = imm_q;
    else if (uop.pc_inc)  pc_d  = pc_q + 1'b1;
    if (uop.ir_ld)        ir_d  = mem_rdata;
    if (uop.imm_ld)       imm_d = mem_rdata;
    if (uop.flg_ld) begin
      z_d = alu_z;
      n_d = alu_n;
    end
  end

  always_ff @(posedge clk or negedge rst_core) begin
    if (!rst_core) begin
      pc_q  <= '0;
      ir_q  <= '0;
      imm_q <= '0;
      z_q   <= 1'b0;
      n_q   <= 1'b0;
    end else begin
      pc_q  <= pc_d;
      ir_q  <= ir_d;
      imm_q <= imm_d;
      z_q   <= z_d;
      n_q   <= n_d;
    end
  end

  assign mem_addr  = (uop.asel == AS_SREG) ? rs_data : pc_q;
  assign mem_re    = uop.rd;
  assign mem_we    = uop.wr;
  assign mem_wdata = rt_data;

  AST_RW_EXCL: assert property (@(posedge clk) disable iff (!rst_core)
    !(mem_re && mem_we)); // R6
  AST_ST_SINGLE: assert property (@(posedge clk) disable iff (!rst_core)
    mem_we |=> !mem_we); // R6
  AST_PC_INC: assert property (@(posedge clk) disable iff (!rst_core)
    uop.pc_inc |=> (pc_q == $past(pc_q) + 1'b1)); // R2
endmodule

// File: tb/tb_ucpu_core.sv
module tb_ucpu_core;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [15:0] mem_addr, mem_wdata, mem_rdata;
  logic        mem_re, mem_we, halted;

  always #2 clk = ~clk;

  ucpu_core dut (
    .clk(clk), .rst_n(rst_n), .mem_addr(mem_addr), .mem_re(mem_re),
    .mem_we(mem_we), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .halted(halted)
  );

  typedef struct {
    bit          re;
    bit          we;
    logic [15:0] a;
    logic [15:0] wd;
    bit          h;
    string       tag;
  } exp_t;

  exp_t        expq[$];
  logic [15:0] prog [256];
  logic [15:0] dm   [256];
  int          checks = 0;
  int          fails  = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 256; i++) dm[i] <= prog[i];
    end else begin
      if (mem_we) dm[mem_addr[7:0]] <= mem_wdata;
      if (mem_re) mem_rdata <= dm[mem_addr[7:0]];
    end
  end

  function automatic logic [15:0] enc(input logic [6:0] o, input logic [2:0] t,
                                      input logic [2:0] s, input logic [2:0] d);
    return {o, t, s, d};
  endfunction

  function automatic logic [15:0] model_alu(input logic [3:0] f,
                                            input logic [15:0] a, input logic [15:0] b);
    case (f)
      4'd0:  return a + b;
      4'd1:  return a - b;
      4'd2:  return a & b;
      4'd3:  return a | b;
      4'd4:  return a ^ b;
      4'd5:  return ~a;
      4'd6:  return a << 1;
      4'd7:  return a >> 1;
      4'd8:  return 16'($signed(a) >>> 1);
      4'd9:  return a;
      4'd10: return b;
      4'd11: return a + 16'd1;
      4'd12: return a - 16'd1;
      4'd13: return 16'd0 - a;
      4'd14: return ~(a & b);
      default: return ~(a | b);
    endcase
  endfunction

  task automatic push(input bit re, input bit we, input logic [15:0] a,
                      input logic [15:0] wd, input bit h, input string tag);
    exp_t e;
    e.re = re; e.we = we; e.a = a; e.wd = wd; e.h = h; e.tag = tag;
    expq.push_back(e);
  endtask

  int p;
  task automatic put(input logic [15:0] w);
    prog[p] = w;
    p++;
  endtask

  task automatic build_program();
    int fix;
    for (int i = 0; i < 256; i++) prog[i] = 16'h0000;
    prog[8'hF0] = 16'hBEEF;
    p = 0;
    put(enc(7'h10, 0, 0, 1)); put(16'h1234);            // R4
    put(enc(7'h10, 0, 0, 2)); put(16'h80FF);
    put(enc(7'h10, 0, 0, 7)); put(16'h0080);
    for (int f = 0; f < 16; f++) begin                  // R3 all functions
      put(enc(7'(f), 2, 1, 3));
      put(enc(7'h12, 3, 7, 0));                         // R6
      put(enc(7'd11, 0, 7, 7));
    end
    put(enc(7'h10, 0, 0, 5)); put(16'h00F0);
    put(enc(7'h11, 0, 5, 4));                           // R5
    put(enc(7'h12, 4, 7, 0));
    put(enc(7'h10, 0, 0, 5)); put(16'h0080);
    put(enc(7'h11, 0, 5, 0));                           // R11 store then load
    put(enc(7'h12, 0, 7, 0));
    put(enc(7'h10, 0, 0, 6)); put(16'h0000);
    put(enc(7'h14, 0, 6, 0)); fix = p; put(16'h0000);   // R8 taken zero
    put(enc(7'h12, 1, 7, 0));
    prog[fix] = 16'(p);
    put(enc(7'h15, 0, 1, 0)); put(16'h0070);            // R8 not taken
    put(enc(7'h12, 2, 7, 0));
    put(enc(7'h15, 0, 2, 0)); fix = p; put(16'h0000);   // R8 taken negative
    put(enc(7'h12, 1, 7, 0));
    prog[fix] = 16'(p);
    put(enc(7'h14, 0, 1, 0)); put(16'h0070);            // R8 not taken
    put(enc(7'h40, 1, 2, 3));                           // R9 unassigned
    put(enc(7'h13, 0, 0, 0)); fix = p; put(16'h0000);   // R7
    put(enc(7'h12, 2, 7, 0));
    prog[fix] = 16'(p);
    put(enc(7'h7F, 0, 0, 0));                           // R10
  endtask

  task automatic build_expect();
    logic [15:0] im [256];
    logic [15:0] r  [8];
    logic [15:0] pc, ir, imm;
    logic [6:0]  o;
    bit          done;
    for (int i = 0; i < 256; i++) im[i] = prog[i];
    for (int i = 0; i < 8; i++)   r[i]  = 16'h0000;   // R1 registers cleared
    pc = 16'h0000;
    done = 0;
    while (!done) begin
      push(1, 0, pc, 0, 0, "R2");
      push(0, 0, 0, 0, 0, "R2");
      ir = im[pc[7:0]];
      pc = pc + 16'd1;
      o  = ir[15:9];
      if (o < 7'd16) begin
        r[ir[2:0]] = model_alu(o[3:0], r[ir[5:3]], r[ir[8:6]]);
        push(0, 0, 0, 0, 0, "R3");
      end else if (o == 7'h10) begin
        push(1, 0, pc, 0, 0, "R4");
        imm = im[pc[7:0]]; pc = pc + 16'd1;
        push(0, 0, 0, 0, 0, "R4"); push(0, 0, 0, 0, 0, "R4");
        r[ir[2:0]] = imm;
      end else if (o == 7'h11) begin
        push(1, 0, r[ir[5:3]], 0, 0, "R5");
        push(0, 0, 0, 0, 0, "R5");
        r[ir[2:0]] = im[r[ir[5:3]][7:0]];
      end else if (o == 7'h12) begin
        push(0, 1, r[ir[5:3]], r[ir[8:6]], 0, "R6");
        im[r[ir[5:3]][7:0]] = r[ir[8:6]];
      end else if (o == 7'h13 || o == 7'h14 || o == 7'h15) begin
        push(1, 0, pc, 0, 0, (o == 7'h13) ? "R7" : "R8");
        imm = im[pc[7:0]]; pc = pc + 16'd1;
        push(0, 0, 0, 0, 0, "R8"); push(0, 0, 0, 0, 0, "R8");
        if (o == 7'h13 || (o == 7'h14 && r[ir[5:3]] == 16'h0000) ||
            (o == 7'h15 && r[ir[5:3]][15])) pc = imm;
      end else if (o == 7'h7F) begin
        push(0, 0, 0, 0, 0, "R10");
        for (int k = 0; k < 6; k++) push(0, 0, 0, 0, 1, "R10");
        done = 1;
      end else begin
        push(0, 0, 0, 0, 0, "R9");
      end
    end
  endtask

  initial begin
    exp_t e;
    bit   ok;
    rst_n = 1'b0;
    build_program();
    build_expect();
    repeat (3) begin
      @(negedge clk);
      checks++;
      if (halted !== 1'b0 || mem_we !== 1'b0 || mem_re !== 1'b1 || mem_addr !== 16'h0000) begin
        fails++;
        $display("FAIL R1 reset: re=%0b we=%0b addr=%h halted=%0b expected re=1 we=0 addr=0000 halted=0",
                 mem_re, mem_we, mem_addr, halted);
      end
    end
    @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk);
    @(posedge clk);
    while (expq.size() > 0) begin
      @(negedge clk);
      e = expq.pop_front();
      ok = (mem_re === e.re) && (mem_we === e.we) && (halted === e.h);
      if (e.re || e.we) ok = ok && (mem_addr === e.a);
      if (e.we)         ok = ok && (mem_wdata === e.wd);
      checks++;
      if (!ok) begin
        fails++;
        $display("FAIL %s: re=%0b we=%0b addr=%h wd=%h halted=%0b expected re=%0b we=%0b addr=%h wd=%h halted=%0b",
                 e.tag, mem_re, mem_we, mem_addr, mem_wdata, halted,
                 e.re, e.we, e.a, e.wd, e.h);
      end
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL R10 watchdog: run still active, expected halt");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule